// File: doc/BRIEF.md
# Parallel Port Register Bank

This block is the host-facing register set of a legacy parallel port. A byte-wide register bus with a 2-bit offset, write strobe, read strobe and write data reaches three registers. Offset 0 holds the output data byte. Offset 1 shows the synchronized port status lines and a sticky bus-timeout flag. Offset 2 holds direction, interrupt enable and select-in control. Read data is registered on the read strobe and held until the next read.

The port mode is a plain input: low selects the standard (SPP) mode and high selects the enhanced (EPP) mode. In EPP mode, an external handshake engine raises a cycle-active input for the length of each bus cycle. A counter derived from the clock-frequency parameter flags any cycle that outlasts the configured timeout. A rising edge on the synchronized acknowledge line raises a one-cycle interrupt pulse when that interrupt is enabled.

All port inputs pass through a two-flop synchronizer before any register or edge detector sees them. The synchronizer flops reset to all ones, so the idle-high active-low lines do not produce a false edge when reset is released.

Top module: `pp_regbank`

## Requirements
- R1: The data register (offset 0) resets to 00h. A write at offset 0 updates `pd_o` on the next clock edge. `pd_oe_o` is high whenever the direction bit is 0.
- R2: `rdata_o` resets to 00h. It loads the selected register on the edge where `rd_i` is high and holds its value in every other cycle. Offset 3 reads 00h, and writes to offset 3 have no effect.
- R3: The status byte (offset 1) is laid out as follows:
  - bit 7 reads the inverse of the synchronized `busy_i`;
  - bits 6, 5, 4 and 3 read the synchronized `ack_ni`, `pe_i`, `slct_i` and `err_ni` as they are;
  - bits 2 and 1 always read 1.
  Each input reaches the register view two clock edges after it changes.
- R4: The timeout flag sets on the edge that completes TMO_CYCLES consecutive cycles with both `epp_mode_i` and `epp_cycle_i` high. TMO_CYCLES = CLK_FREQ_HZ/1_000_000*TIMEOUT_US. The count restarts from zero whenever either input is low.
- R5: The timeout flag clears only when offset 1 is written with bit 0 = 1. Writing bit 0 = 0 leaves it set. A set condition in the same cycle wins over the clear.
- R6: Status bit 0 returns the timeout flag in EPP mode and always reads 1 in SPP mode.
- R7: The control byte (offset 2) is laid out as follows:
  - bits 7 and 6 read 1;
  - bits 2 to 0 read 0;
  - bit 4 is the interrupt enable;
  - bit 3 is the select-in bit, and `slin_no` drives its inverse.
- R8: Control bit 5 (1 = input) is writable only in EPP mode and is cleared on every edge in SPP mode. While it is 1, `pd_oe_o` is low and an offset-0 read returns the synchronized `pd_i`.
- R9: `irq_o` is a one-cycle pulse in the cycle after the synchronized `ack_ni` goes from 0 to 1, and only while the interrupt enable is 1. No pulse follows reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| epp_mode_i | input | 1 | 1 = EPP mode, 0 = SPP mode |
| epp_cycle_i | input | 1 | EPP bus cycle in progress |
| busy_i | input | 1 | Port BUSY line |
| ack_ni | input | 1 | Port acknowledge line, active low |
| pe_i | input | 1 | Port paper-end line |
| slct_i | input | 1 | Port select line |
| err_ni | input | 1 | Port error line, active low |
| pd_i | input | 8 | Sampled port data lines |
| pd_o | output | 8 | Port data lines driven out |
| pd_oe_o | output | 1 | Data line output enable |
| slin_no | output | 1 | Select-in line, active low |
| irq_o | output | 1 | Acknowledge interrupt pulse |

## Verification
The bench builds the block with CLK_FREQ_HZ = 2 MHz and TIMEOUT_US = 3, so the timeout window is only six cycles. With that window, both sides of the boundary can be driven directly. A five-cycle bus cycle must leave the flag clear and an eight-cycle one must set it. A clear-by-write can then be tested against a flag that was genuinely raised. The default 50 MHz setting, with its 500-cycle window, is only elaborated.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_W = 5;   // busy, ack_n, pe, slct, err_n
  localparam int unsigned PD_W   = 8;
  localparam int unsigned SYNC_W = PD_W + STAT_W;

  localparam int unsigned CTRL_DIR_BIT  = 5;
  localparam int unsigned CTRL_IRQ_BIT  = 4;
  localparam int unsigned CTRL_SLIN_BIT = 3;
  localparam int unsigned STAT_TMO_BIT  = 0;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pp_epp_timeout.sv
module pp_epp_timeout #(
  parameter int unsigned CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_en_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
  localparam logic [CW-1:0] FULL = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic          hit;

  assign hit = count_en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!count_en_i) begin
      cnt_q <= '0;
    end else if (cnt_q != FULL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hit)    flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pp_ack_irq.sv
module pp_ack_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_s_i,
  input  logic en_i,
  output logic irq_o
);
  logic ack_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_d_q <= 1'b1;
    else         ack_d_q <= ack_s_i;
  end

  assign irq_o = en_i && ack_s_i && !ack_d_q;
endmodule

// File: rtl/pp_regbank.sv
module pp_regbank
  import pp_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned TIMEOUT_US  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       epp_mode_i,
  input  logic       epp_cycle_i,
  input  logic       busy_i,
  input  logic       ack_ni,
  input  logic       pe_i,
  input  logic       slct_i,
  input  logic       err_ni,
  input  logic [7:0] pd_i,
  output logic [7:0] pd_o,
  output logic       pd_oe_o,
  output logic       slin_no,
  output logic       irq_o
);
  localparam int unsigned TICKS_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int unsigned TMO_CYCLES   = (TICKS_PER_US * TIMEOUT_US < 1) ? 1
                                         : TICKS_PER_US * TIMEOUT_US;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  // input synchronization
  logic [SYNC_W-1:0] sync_d, sync_q;
  logic [PD_W-1:0]   pd_s;
  logic              busy_s, ack_s, pe_s, slct_s, err_s;

  assign sync_d = {pd_i, busy_i, ack_ni, pe_i, slct_i, err_ni};

  pp_sync #(.W(SYNC_W), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {pd_s, busy_s, ack_s, pe_s, slct_s, err_s} = sync_q;

  // registers
  logic [7:0] data_q;
  logic       dir_q, irq_en_q, slin_q;
  logic       wr_data, wr_stat, wr_ctrl;

  assign wr_data = wr_i && (sel == SEL_DATA);
  assign wr_stat = wr_i && (sel == SEL_STAT);
  assign wr_ctrl = wr_i && (sel == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (wr_data) data_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      slin_q   <= 1'b0;
    end else if (wr_ctrl) begin
      irq_en_q <= wdata_i[CTRL_IRQ_BIT];
      slin_q   <= wdata_i[CTRL_SLIN_BIT];
    end
  end

  // direction is held at output while in SPP mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dir_q <= 1'b0;
    else if (!epp_mode_i) dir_q <= 1'b0;
    else if (wr_ctrl)     dir_q <= wdata_i[CTRL_DIR_BIT];
  end

  // timeout
  logic tmo_flag;

  pp_epp_timeout #(.CYCLES(TMO_CYCLES)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_en_i(epp_mode_i && epp_cycle_i),
    .clr_i     (wr_stat && wdata_i[STAT_TMO_BIT]),
    .flag_o    (tmo_flag)
  );

  // ack edge interrupt
  pp_ack_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_s_i(ack_s),
    .en_i   (irq_en_q),
    .irq_o  (irq_o)
  );

  // read path
  logic [7:0] stat_view, ctrl_view, rd_mux;

  assign stat_view = {~busy_s, ack_s, pe_s, slct_s, err_s, 2'b11,
                      (epp_mode_i ? tmo_flag : 1'b1)};
  assign ctrl_view = {2'b11, dir_q, irq_en_q, slin_q, 3'b000};

  always_comb begin
    unique case (sel)
      SEL_DATA:  rd_mux = dir_q ? pd_s : data_q;
      SEL_STAT:  rd_mux = stat_view;
      SEL_CTRL:  rd_mux = ctrl_view;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign pd_o    = data_q;
  assign pd_oe_o = ~dir_q;
  assign slin_no = ~slin_q;
endmodule

// File: rtl/pp_regbank_chk.sv
module pp_regbank_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       epp_mode_i,
  input logic       epp_cycle_i,
  input logic [7:0] pd_o,
  input logic       pd_oe_o,
  input logic       slin_no,
  input logic       irq_o,
  input logic       tmo_flag_i
);
  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd0) |=> (pd_o == $past(wdata_i))); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R2

  AST_TMO_SET_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag_i) |-> $past(epp_mode_i && epp_cycle_i)); // R4

  AST_TMO_NO_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_flag_i && !(wr_i && addr_i == 2'd1 && wdata_i[0])) |=> tmo_flag_i); // R5

  AST_SLIN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2) |=> (slin_no == !$past(wdata_i[3]))); // R7

  AST_SPP_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epp_mode_i |=> pd_oe_o); // R8

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9

  AST_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2 && !wdata_i[4]) |=> !irq_o); // R9
endmodule

bind pp_regbank pp_regbank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .epp_mode_i (epp_mode_i),
  .epp_cycle_i(epp_cycle_i),
  .pd_o       (pd_o),
  .pd_oe_o    (pd_oe_o),
  .slin_no    (slin_no),
  .irq_o      (irq_o),
  .tmo_flag_i (tmo_flag)
);

// File: tb/sim_pp_regbank.sv
`timescale 1ns/1ps
module sim_pp_regbank;
  localparam int FREQ = 2_000_000;
  localparam int TUS  = 3;
  localparam int TMO  = FREQ / 1_000_000 * TUS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       mode = 1'b0, cyc = 1'b0;
  logic       busy = 1'b0, ack_n = 1'b1, pe = 1'b0, slct = 1'b0, err_n = 1'b1;
  logic [7:0] pdi = '0;
  logic [7:0] pdo;
  logic       pdoe, slin_n, irq;

  int checks = 0, fails = 0;
  int cyc_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pp_regbank #(.CLK_FREQ_HZ(FREQ), .TIMEOUT_US(TUS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .epp_mode_i(mode), .epp_cycle_i(cyc),
    .busy_i(busy), .ack_ni(ack_n), .pe_i(pe), .slct_i(slct), .err_ni(err_n),
    .pd_i(pdi), .pd_o(pdo), .pd_oe_o(pdoe), .slin_no(slin_n), .irq_o(irq)
  );

  // behavioural reference state
  logic [12:0] m_s1 = '1, m_s2 = '1;
  logic [7:0]  m_data = 0, m_rdata = 0;
  logic        m_dir = 0, m_en = 0, m_slin = 0, m_flag = 0, m_ackd = 1;
  int          m_cnt = 0;

  function automatic logic [7:0] m_view(input logic [1:0] a);
    logic [7:0] v;
    case (a)
      2'd0: v = m_dir ? m_s2[12:5] : m_data;
      2'd1: v = {~m_s2[4], m_s2[3], m_s2[2], m_s2[1], m_s2[0], 2'b11,
                 (mode ? m_flag : 1'b1)};
      2'd2: v = {2'b11, m_dir, m_en, m_slin, 3'b000};
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_data = 0; m_rdata = 0; m_dir = 0; m_en = 0;
      m_slin = 0; m_flag = 0; m_ackd = 1; m_cnt = 0;
    end else begin
      logic [7:0] nr;
      logic set;
      nr  = rd ? m_view(addr) : m_rdata;
      set = mode && cyc && (m_cnt == TMO - 1);
      if (mode && cyc) begin if (m_cnt < TMO) m_cnt++; end else m_cnt = 0;
      if (set) m_flag = 1;
      else if (wr && addr == 1 && wdata[0]) m_flag = 0;
      if (wr && addr == 0) m_data = wdata;
      if (wr && addr == 2) begin m_en = wdata[4]; m_slin = wdata[3]; end
      if (!mode) m_dir = 0; else if (wr && addr == 2) m_dir = wdata[5];
      m_ackd = m_s2[3];
      m_s2 = m_s1;
      m_s1 = {pdi, busy, ack_n, pe, slct, err_n};
      m_rdata = nr;
    end
    #3;
    if (rst_n && !done) begin
      chk("R2 rdata", rdata, m_rdata);
      chk("R1 pd_o", pdo, m_data);
      chk("R8 pd_oe", pdoe, !m_dir);
      chk("R7 slin_n", slin_n, !m_slin);
      chk("R9 irq", irq, m_en && m_s2[3] && !m_ackd);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int pulses;
    idle(2);
    chk("R1 reset pd_o", pdo, 0);
    chk("R2 reset rdata", rdata, 0);
    chk("R9 reset irq", irq, 0);
    rst_n = 1;
    idle(3);
    chk("R9 no irq after reset", irq, 0);
    rd_chk(2'd0, 8'h00, "R1 data reset value");

    wr_reg(2'd0, 8'h5A);
    chk("R1 pd_o after write", pdo, 8'h5A);
    chk("R1 oe high", pdoe, 1);
    rd_chk(2'd0, 8'h5A, "R1 data readback");
    wr_reg(2'd3, 8'hFF);
    rd_chk(2'd3, 8'h00, "R2 spare reads zero");
    idle(2);
    chk("R2 rdata held", rdata, 8'h00);

    busy = 1; ack_n = 0; pe = 1; slct = 0; err_n = 1;
    idle(3);
    rd_chk(2'd1, 8'h2F, "R3 R6 status pattern A spp");
    busy = 0; ack_n = 1; pe = 0; slct = 1; err_n = 0;
    idle(3);
    rd_chk(2'd1, 8'hD7, "R3 R6 status pattern B spp");

    wr_reg(2'd2, 8'h3F);
    rd_chk(2'd2, 8'hD8, "R7 R8 ctrl in spp");
    chk("R7 slin_n low", slin_n, 0);
    mode = 1;
    idle(1);
    rd_chk(2'd1, 8'hD6, "R6 status epp flag clear");
    wr_reg(2'd2, 8'h3F);
    rd_chk(2'd2, 8'hF8, "R7 R8 ctrl in epp");
    chk("R8 oe low", pdoe, 0);
    pdi = 8'hA5;
    idle(3);
    rd_chk(2'd0, 8'hA5, "R8 input read");
    chk("R8 pd_o kept", pdo, 8'h5A);
    mode = 0;
    idle(2);
    chk("R8 spp forces output", pdoe, 1);
    mode = 1;
    wr_reg(2'd2, 8'h00);
    rd_chk(2'd2, 8'hC0, "R7 ctrl cleared");

    // timeout window
    cyc = 1; idle(TMO - 1); cyc = 0; idle(1);
    rd_chk(2'd1, 8'hD6, "R4 short cycle no flag");
    cyc = 1; idle(TMO + 2); cyc = 0; idle(1);
    rd_chk(2'd1, 8'hD7, "R4 long cycle flag set");
    wr_reg(2'd1, 8'h00);
    rd_chk(2'd1, 8'hD7, "R5 write zero keeps flag");
    mode = 0;
    idle(1);
    rd_chk(2'd1, 8'hD7, "R6 spp reads one");
    mode = 1;
    wr_reg(2'd1, 8'h01);
    rd_chk(2'd1, 8'hD6, "R5 write one clears flag");

    // interrupt
    wr_reg(2'd2, 8'h10);
    ack_n = 0; idle(4);
    pulses = 0; ack_n = 1;
    repeat (6) begin @(posedge clk); #2; if (irq) pulses++; end
    chk("R9 one pulse enabled", pulses, 1);
    wr_reg(2'd2, 8'h00);
    ack_n = 0; idle(4);
    pulses = 0; ack_n = 1;
    repeat (6) begin @(posedge clk); #2; if (irq) pulses++; end
    chk("R9 no pulse disabled", pulses, 0);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule